// File: doc/BRIEF.md
# Nine-Bit Serial Command Writer

This block sends one display-controller command over a three-wire serial link whose words are nine bits wide. The top bit of each word tells the panel whether the low eight bits are a command or a parameter. The host first writes the parameter bytes into a small buffer. It then pulses a start strobe with the command byte, the number of parameters and a clock divider setting. The block frames the command word and every parameter word inside one chip-select assertion. It then pulses a completion flag, or an error flag if the request was too long.

The serial clock idles low. Data is launched on the falling edge and sampled by the panel on the rising edge, most significant bit first. The divider sets how many system clocks each half of the serial clock lasts. Chip select leads the first rising edge and trails the last falling edge by at least one such half period.

Top module: `nine_bit_cmd_writer`

## Requirements
- R1: After reset and while idle: cs_n = 1, sclk = 0, sdo = 0, busy = 0, done = 0, err = 0.
- R2: The first word of an accepted request is 0 in bit 8 followed by cmd_byte[7:0], shifted bit 8 first and bit 0 last.
- R3: Parameter word k (k = 0 .. par_count-1) is 1 in bit 8 followed by the byte last written to buffer address k, shifted bit 8 first.
- R4: All words of one request go out within one low period of cs_n, and that period holds exactly 9*(par_count+1) rising sclk edges; for the largest legal count of 15 this is 144 edges.
- R5: A start with par_count greater than 15 raises err for exactly one cycle, one clock after the start. cs_n, sclk, sdo and busy stay at their idle values.
- R6: A start with par_count = 0 sends exactly one 9-bit word, which gives 9 rising sclk edges.
- R7: sclk is high only while cs_n is low, and sdo changes only while sclk is low (on the falling edge or at frame boundaries).
- R8: With H = div_half+1, latched at start, each high and each low half of sclk lasts H clocks. cs_n falls H clocks before the first rising edge and rises H clocks after the last falling edge.
- R9: busy rises together with cs_n falling, on the clock after an accepted start, and falls together with cs_n rising. A start while busy is high is ignored.
- R10: done pulses for one cycle in the cycle where cs_n returns high. A new start presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_we | input | 1 | Parameter buffer write enable |
| par_addr | input | 4 | Parameter buffer write address |
| par_wdata | input | 8 | Parameter byte to store |
| div_half | input | 8 | Half serial period in clocks, minus one |
| start | input | 1 | Request strobe, sampled only while idle |
| cmd_byte | input | 8 | Command byte for the first word |
| par_count | input | 5 | Number of parameters to follow |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |

## Verification
The hardest situations to reach are a start that arrives exactly in the completion cycle and a start that arrives in the middle of a frame. The stimulus produces the first by issuing the next request on the very cycle the reference model pops its completion entry. It produces the second by pulsing start with a different command partway through a slow-clocked frame, and every serial output must stay on the original stream. The full 15-parameter burst and an oversize count of 16 and of 31 bracket the length limit.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_HOLD = 2'd3
  } nbw_state_t;
endpackage

// File: rtl/nbw_param_ram.sv
module nbw_param_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 15,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nbw_half_timer.sv
module nbw_half_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);
endmodule

// File: rtl/nine_bit_cmd_writer.sv
module nine_bit_cmd_writer #(
  parameter int MAX_WORDS = 16,
  parameter int DIVW      = 8,
  localparam int MAXP     = MAX_WORDS - 1,
  localparam int CW       = $clog2(MAX_WORDS) + 1,
  localparam int AW       = (MAXP > 1) ? $clog2(MAXP) : 1,
  localparam int WORD_W   = 9,
  localparam int BW       = $clog2(WORD_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            par_we,
  input  logic [AW-1:0]   par_addr,
  input  logic [7:0]      par_wdata,
  input  logic [DIVW-1:0] div_half,
  input  logic            start,
  input  logic [7:0]      cmd_byte,
  input  logic [CW-1:0]   par_count,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            cs_n,
  output logic            sclk,
  output logic            sdo
);
  import nbw_pkg::*;

  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  nbw_state_t        state_q;
  logic [WORD_W-1:0] word_q;
  logic [BW-1:0]     bitc_q;
  logic [CW-1:0]     sent_q, total_q;
  logic [AW-1:0]     ptr_q;
  logic [DIVW-1:0]   div_q;
  logic              cs_n_q, sclk_q, busy_q, done_q, err_q;
  logic              tick;
  logic [7:0]        par_rd;

  nbw_param_ram #(.DW(8), .DEPTH(MAXP)) u_ram (
    .clk(clk), .we(par_we), .waddr(par_addr), .wdata(par_wdata),
    .raddr(ptr_q), .rdata(par_rd)
  );

  nbw_half_timer #(.W(DIVW)) u_timer (
    .clk(clk), .rst(rst), .clear(state_q == ST_IDLE),
    .limit(div_q), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      bitc_q  <= '0;
      sent_q  <= '0;
      total_q <= '0;
      ptr_q   <= '0;
      div_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          if (par_count > CW'(MAXP)) begin
            err_q <= 1'b1;
          end else begin
            cs_n_q  <= 1'b0;
            busy_q  <= 1'b1;
            word_q  <= {1'b0, cmd_byte};
            bitc_q  <= '0;
            sent_q  <= '0;
            total_q <= par_count;
            ptr_q   <= '0;
            div_q   <= div_half;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: if (tick) begin
          sclk_q  <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (bitc_q != LAST_BIT) begin
            word_q  <= {word_q[WORD_W-2:0], 1'b0};
            bitc_q  <= bitc_q + 1'b1;
            state_q <= ST_LOW;
          end else if (sent_q != total_q) begin
            word_q  <= {1'b1, par_rd};
            bitc_q  <= '0;
            sent_q  <= sent_q + 1'b1;
            ptr_q   <= ptr_q + 1'b1;
            state_q <= ST_LOW;
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (tick) begin
          cs_n_q  <= 1'b1;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          word_q  <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n = cs_n_q;
  assign sclk = sclk_q;
  assign sdo  = word_q[WORD_W-1];
  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  assert_sclk_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> !cs_n_q);
  assert_sdo_moves_low_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> !sclk_q);
  assert_reject_silent_R5: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (cs_n_q && !busy_q));
  assert_busy_frames_cs_R9: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !cs_n_q);
  assert_done_at_release_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $rose(cs_n_q));
  assert_bit_range_R2: assert property (@(posedge clk) disable iff (rst)
    bitc_q <= LAST_BIT);
  assert_param_bound_R3: assert property (@(posedge clk) disable iff (rst)
    sent_q <= total_q);
endmodule

// File: tb/nine_bit_cmd_writer_test.sv
module nine_bit_cmd_writer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_we = 1'b0;
  logic [3:0] par_addr = '0;
  logic [7:0] par_wdata = '0;
  logic [7:0] div_half = '0;
  logic       start = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [4:0] par_count = '0;
  logic busy, done, err, cs_n, sclk, sdo;

  always #2.5 clk = ~clk;

  nine_bit_cmd_writer uut (
    .clk(clk), .rst(rst), .par_we(par_we), .par_addr(par_addr),
    .par_wdata(par_wdata), .div_half(div_half), .start(start),
    .cmd_byte(cmd_byte), .par_count(par_count), .busy(busy), .done(done),
    .err(err), .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
  );

  // expected tuple: {cs_n, sclk, sdo, busy, done, err}
  logic [5:0] expq[$];
  logic [7:0] pbuf [15];
  int vectors = 0;
  int fails = 0;
  int rises = 0;
  logic prev_sclk = 1'b0;
  string tag = "R1";
  bit finished = 0;

  function automatic logic [5:0] ent(logic c, logic s, logic d, logic b, logic dn, logic e);
    return {c, s, d, b, dn, e};
  endfunction

  task automatic tick_check();
    logic [5:0] exp_v, act_v;
    @(negedge clk);
    exp_v = (expq.size() > 0) ? expq.pop_front() : ent(1, 0, 0, 0, 0, 0);
    act_v = {cs_n, sclk, sdo, busy, done, err};
    vectors++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: {cs_n,sclk,sdo,busy,done,err} actual %b expected %b at %0t",
               tag, act_v, exp_v, $time);
    end
    if (sclk && !prev_sclk) rises++;
    prev_sclk = sclk;
  endtask

  task automatic write_par(int i, logic [7:0] v);
    par_we = 1'b1; par_addr = 4'(i); par_wdata = v; pbuf[i] = v;
    tick_check();
    par_we = 1'b0;
  endtask

  task automatic push_xfer(logic [7:0] c, int n, int h);
    logic [8:0] wd;
    for (int w = 0; w <= n; w++) begin
      wd = (w == 0) ? {1'b0, c} : {1'b1, pbuf[w-1]};
      for (int b = 8; b >= 0; b--) begin
        for (int k = 0; k < h; k++) expq.push_back(ent(0, 0, wd[b], 1, 0, 0));
        for (int k = 0; k < h; k++) expq.push_back(ent(0, 1, wd[b], 1, 0, 0));
      end
    end
    for (int k = 0; k < h; k++) expq.push_back(ent(0, 0, wd[0], 1, 0, 0));
    expq.push_back(ent(1, 0, 0, 0, 1, 0));
  endtask

  task automatic request(logic [7:0] c, int n, int dh);
    cmd_byte = c; par_count = 5'(n); div_half = 8'(dh); start = 1'b1;
    if (expq.size() == 0) begin
      if (n > 15) expq.push_back(ent(1, 0, 0, 0, 0, 1));
      else begin
        push_xfer(c, n, dh + 1);
        rises = 0;
      end
    end
    tick_check();
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (expq.size() > 0) tick_check();
  endtask

  task automatic check_rises(int n, string t);
    vectors++;
    if (rises != 9 * (n + 1)) begin
      fails++;
      $display("FAIL %s: sclk rising edges actual %0d expected %0d", t, rises, 9 * (n + 1));
    end
  endtask

  initial begin
    for (int i = 0; i < 15; i++) pbuf[i] = '0;
    tag = "R1";
    repeat (4) tick_check();
    rst = 1'b0;
    repeat (3) tick_check();
    for (int i = 0; i < 15; i++) write_par(i, 8'((i * 37 + 5) ^ 8'hA0));

    tag = "R6"; // zero parameters, one word
    request(8'h29, 0, 0);
    wait_idle();
    check_rises(0, "R6");

    tag = "R3"; // three parameters, H=2, back to back after done (R10)
    write_par(0, 8'h5A); write_par(1, 8'hA5); write_par(2, 8'h01);
    request(8'hB6, 3, 1);
    wait_idle();
    check_rises(3, "R3");
    tag = "R10";
    request(8'h36, 1, 0);
    wait_idle();
    check_rises(1, "R10");

    tag = "R4"; // largest legal burst
    request(8'h11, 15, 0);
    wait_idle();
    check_rises(15, "R4");

    tag = "R5"; // oversize requests are rejected
    request(8'h33, 16, 0);
    repeat (3) tick_check();
    request(8'h44, 31, 2);
    repeat (3) tick_check();

    tag = "R9"; // start during a frame is ignored
    request(8'hC3, 1, 2);
    repeat (20) tick_check();
    request(8'hFF, 0, 0);
    wait_idle();
    check_rises(1, "R9");

    tag = "R8"; // slower divider
    request(8'h81, 1, 4);
    wait_idle();
    check_rises(1, "R8");

    tag = "R2";
    request(8'h7E, 2, 0);
    wait_idle();
    check_rises(2, "R2");
    tag = "R7";
    repeat (5) tick_check();

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule